// File: doc/BRIEF.md
# Link Bring-up Sequencer

This block walks a high-speed serial Ethernet port from reset to a usable link. It orders the bring-up phases, hands each phase's work to the logic around it, and waits for that logic to report completion. The phases run in this order:

1. Reconfigure the PHY for auto-negotiation.
2. Hold the transmitter silent so that any partner falls back into negotiation.
3. Start the base-page exchange and wait for auto-negotiation to finish.
4. Reconfigure the PHY for training and wait for both ends to finish training.
5. Reconfigure the PHY for the data rate and wait for receive lock.

The page exchange, the training algorithm, the PHY and the PCS all sit outside the block. It only sees their handshakes and status.

Three cycle-count timers set how the block recovers:
- **Quiet timer.** Sets how long the transmitter stays silent.
- **Lock deadline.** Starts when the training reconfiguration begins. If no lock has been found when it runs out, the sequence restarts from the top.
- **Grace window.** Starts when lock is lost on a ready link. If lock returns within the window, the block goes back to ready. Otherwise the sequence restarts.

Every timer length is a parameter in clock cycles, so a system can set real-time values and a test can set short ones.

Top module: `link_bringup_seq`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in the enable state with all timers cleared and `rcfg_req`, `tx_disable`, `base_page_start` and `link_up` low. The enable state holds while `an_lt_en` is low and moves to the auto-negotiation reconfiguration state on the first cycle `an_lt_en` is high.
- R2: In each of the three reconfiguration states, `rcfg_req` is high and `rcfg_mode` selects the target: 1 for auto-negotiation, 2 for training, 3 for data rate. In every other state `rcfg_req` is low and `rcfg_mode` is 0. A reconfiguration state advances only in a cycle where `rcfg_done` is high.
- R3: The quiet (ability-detect) state lasts exactly `QUIET_CYCLES` cycles, whatever the other inputs do, and `tx_disable` is high throughout.
- R4: `base_page_start` is high for exactly one cycle, the last cycle of the quiet state. The block then stays in the negotiation-check state until `an_done` is high, and then moves to the training reconfiguration state.
- R5: The training-check state holds until `lt_done` is high, and then moves to the data-rate reconfiguration state.
- R6: The lock-check state moves to ready once `rx_align_lock` and `rx_cdr_lock` are both high. `link_up` is high in the ready state and in no other state.
- R7: From entry into the training reconfiguration state, the block may spend at most `DEADLINE_CYCLES` cycles across these four states before reaching ready:
  - training reconfiguration
  - training check
  - data-rate reconfiguration
  - lock check

  After the last allowed cycle it returns to the enable state. Lock found in the final lock-check cycle still wins.
- R8: In the ready state, a cycle in which either `rx_align_lock` or `rx_cdr_lock` is low moves the block to the loss-of-lock wait state.
- R9: The loss-of-lock wait state returns to ready on the first cycle in which both locks are high. If lock has not returned after `GRACE_CYCLES` cycles in that state, the block goes to the enable state.
- R10: `state_code` reports the state with this encoding: 0 enable, 1 auto-negotiation reconfiguration, 2 quiet, 3 negotiation check, 4 training reconfiguration, 5 training check, 6 data-rate reconfiguration, 7 lock check, 8 ready, 9 loss-of-lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| an_lt_en | input | 1 | Allows the sequence to leave the enable state |
| rcfg_done | input | 1 | The requested PHY reconfiguration has finished |
| an_done | input | 1 | Auto-negotiation complete |
| lt_done | input | 1 | Link training complete at both ends |
| rx_align_lock | input | 1 | Receive alignment / deskew lock |
| rx_cdr_lock | input | 1 | CDR locked to data |
| state_code | output | 4 | Current state, encoded as in R10 |
| rcfg_req | output | 1 | PHY reconfiguration request |
| rcfg_mode | output | 2 | Reconfiguration target (R2) |
| tx_disable | output | 1 | Transmitter held silent |
| base_page_start | output | 1 | One-cycle start of base-page transmission |
| link_up | output | 1 | Link ready |

## Verification
The bench builds the block with `QUIET_CYCLES` = 20, `DEADLINE_CYCLES` = 60 and `GRACE_CYCLES` = 10. These short values let every timer run to its end within a few hundred cycles. The bench therefore checks the exact quiet length and the exact cycle of the base-page pulse. It runs the deadline out twice, once while stalled in training and once while waiting for lock. It also runs the grace window both to recovery and to expiry. Ten states and three timers of those lengths stay small enough for the bound checker counters to track each window cycle by cycle.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   localparam int unsigned STATE_W = 4;
   localparam int unsigned MODE_W  = 2;

   // Numeric order is observable through state_code
   typedef enum logic [STATE_W-1:0] {
      ST_IDLE_EN   = 4'd0,
      ST_CFG_AN    = 4'd1,
      ST_QUIET     = 4'd2,
      ST_NEGOTIATE = 4'd3,
      ST_CFG_TRAIN = 4'd4,
      ST_TRAIN     = 4'd5,
      ST_CFG_DATA  = 4'd6,
      ST_ACQUIRE   = 4'd7,
      ST_READY     = 4'd8,
      ST_GRACE     = 4'd9
   } bup_state_e;

   typedef enum logic [MODE_W-1:0] {
      CFG_NONE  = 2'd0,
      CFG_AN    = 2'd1,
      CFG_TRAIN = 2'd2,
      CFG_DATA  = 2'd3
   } cfg_mode_e;
endpackage

// File: rtl/lbs_window_timer.sv
// Counts consecutive cycles with run high; hit marks the LIMIT-th such cycle.
module lbs_window_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic hit
);
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign hit = run && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lbs_seq_fsm.sv
module lbs_seq_fsm
   import lbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       an_lt_en,
   input  logic       cfg_done,
   input  logic       an_done,
   input  logic       lt_done,
   input  logic       lock_ok,
   input  logic       quiet_hit,
   input  logic       deadline_hit,
   input  logic       grace_hit,
   output bup_state_e state_q
);
   bup_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE_EN:   if (an_lt_en) state_d = ST_CFG_AN;
         ST_CFG_AN:    if (cfg_done) state_d = ST_QUIET;
         ST_QUIET:     if (quiet_hit) state_d = ST_NEGOTIATE;
         ST_NEGOTIATE: if (an_done) state_d = ST_CFG_TRAIN;
         ST_CFG_TRAIN: begin
            if (deadline_hit)  state_d = ST_IDLE_EN;
            else if (cfg_done) state_d = ST_TRAIN;
         end
         ST_TRAIN: begin
            if (deadline_hit) state_d = ST_IDLE_EN;
            else if (lt_done) state_d = ST_CFG_DATA;
         end
         ST_CFG_DATA: begin
            if (deadline_hit)  state_d = ST_IDLE_EN;
            else if (cfg_done) state_d = ST_ACQUIRE;
         end
         ST_ACQUIRE: begin
            if (lock_ok)           state_d = ST_READY;
            else if (deadline_hit) state_d = ST_IDLE_EN;
         end
         ST_READY:     if (!lock_ok) state_d = ST_GRACE;
         ST_GRACE: begin
            if (lock_ok)        state_d = ST_READY;
            else if (grace_hit) state_d = ST_IDLE_EN;
         end
         default:      state_d = ST_IDLE_EN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE_EN;
      else     state_q <= state_d;
   end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
   import lbs_pkg::*;
#(
   parameter int unsigned QUIET_CYCLES    = 9_375_000,
   parameter int unsigned DEADLINE_CYCLES = 62_500_000,
   parameter int unsigned GRACE_CYCLES    = 1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              an_lt_en,
   input  logic              rcfg_done,
   input  logic              an_done,
   input  logic              lt_done,
   input  logic              rx_align_lock,
   input  logic              rx_cdr_lock,
   output logic [STATE_W-1:0] state_code,
   output logic              rcfg_req,
   output logic [MODE_W-1:0] rcfg_mode,
   output logic              tx_disable,
   output logic              base_page_start,
   output logic              link_up
);
   if (QUIET_CYCLES < 2) begin : g_bad_quiet
      $error("QUIET_CYCLES must be at least 2");
   end
   if (GRACE_CYCLES < 1) begin : g_bad_grace
      $error("GRACE_CYCLES must be at least 1");
   end
   if (DEADLINE_CYCLES < 8) begin : g_bad_deadline
      $error("DEADLINE_CYCLES must cover the four bounded states");
   end

   bup_state_e state_q;
   cfg_mode_e  mode;
   logic       lock_ok;
   logic       quiet_run, deadline_run, grace_run;
   logic       quiet_hit, deadline_hit, grace_hit;

   assign lock_ok      = rx_align_lock && rx_cdr_lock;
   assign quiet_run    = (state_q == ST_QUIET);
   assign grace_run    = (state_q == ST_GRACE);
   assign deadline_run = (state_q == ST_CFG_TRAIN) || (state_q == ST_TRAIN) ||
                         (state_q == ST_CFG_DATA)  || (state_q == ST_ACQUIRE);

   lbs_window_timer #(.LIMIT(QUIET_CYCLES)) quiet_tmr_i (
      .clk(clk), .rst(rst), .run(quiet_run), .hit(quiet_hit)
   );
   lbs_window_timer #(.LIMIT(DEADLINE_CYCLES)) deadline_tmr_i (
      .clk(clk), .rst(rst), .run(deadline_run), .hit(deadline_hit)
   );
   lbs_window_timer #(.LIMIT(GRACE_CYCLES)) grace_tmr_i (
      .clk(clk), .rst(rst), .run(grace_run), .hit(grace_hit)
   );

   lbs_seq_fsm fsm_i (
      .clk(clk), .rst(rst), .an_lt_en(an_lt_en), .cfg_done(rcfg_done),
      .an_done(an_done), .lt_done(lt_done), .lock_ok(lock_ok),
      .quiet_hit(quiet_hit), .deadline_hit(deadline_hit),
      .grace_hit(grace_hit), .state_q(state_q)
   );

   always_comb begin
      unique case (state_q)
         ST_CFG_AN:    mode = CFG_AN;
         ST_CFG_TRAIN: mode = CFG_TRAIN;
         ST_CFG_DATA:  mode = CFG_DATA;
         default:      mode = CFG_NONE;
      endcase
   end

   assign state_code      = state_q;
   assign rcfg_mode       = mode;
   assign rcfg_req        = (mode != CFG_NONE);
   assign tx_disable      = quiet_run;
   assign base_page_start = quiet_hit;
   assign link_up         = (state_q == ST_READY);
endmodule

// File: rtl/link_bringup_seq_chk.sv
module link_bringup_seq_chk
   import lbs_pkg::*;
#(
   parameter int unsigned QUIET_CYCLES    = 9_375_000,
   parameter int unsigned DEADLINE_CYCLES = 62_500_000,
   parameter int unsigned GRACE_CYCLES    = 1000
) (
   input logic               clk,
   input logic               rst,
   input logic               rcfg_done,
   input logic               an_done,
   input logic               lt_done,
   input logic               rx_align_lock,
   input logic               rx_cdr_lock,
   input logic [STATE_W-1:0] state_code,
   input logic               rcfg_req,
   input logic [MODE_W-1:0]  rcfg_mode,
   input logic               tx_disable,
   input logic               base_page_start,
   input logic               link_up
);
   int unsigned qcnt, dcnt, gcnt;
   logic in_window;
   logic both_lock;

   assign both_lock = rx_align_lock && rx_cdr_lock;
   assign in_window = (state_code >= ST_CFG_TRAIN) && (state_code <= ST_ACQUIRE);

   always_ff @(posedge clk) begin
      if (rst) begin
         qcnt <= 0; dcnt <= 0; gcnt <= 0;
      end else begin
         qcnt <= (state_code == ST_QUIET) ? qcnt + 1 : 0;
         dcnt <= in_window ? dcnt + 1 : 0;
         gcnt <= (state_code == ST_GRACE) ? gcnt + 1 : 0;
      end
   end

   AST_RESET_TO_ENABLE: assert property (@(posedge clk) rst |=> state_code == ST_IDLE_EN); // R1
   AST_REQ_HAS_MODE: assert property (@(posedge clk) disable iff (rst) rcfg_req |-> rcfg_mode != 2'd0); // R2
   AST_CFG_AN_WAITS: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_CFG_AN && !rcfg_done) |=> state_code == ST_CFG_AN); // R2
   AST_QUIET_TX_OFF: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_QUIET) |-> tx_disable); // R3
   AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_QUIET) |-> qcnt < QUIET_CYCLES); // R3
   AST_BASE_PAGE_EXIT: assert property (@(posedge clk) disable iff (rst)
      base_page_start |=> state_code == ST_NEGOTIATE); // R4
   AST_NEGOTIATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_NEGOTIATE && !an_done) |=> state_code == ST_NEGOTIATE); // R4
   AST_TRAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_TRAIN && lt_done && dcnt + 1 < DEADLINE_CYCLES) |=> state_code == ST_CFG_DATA); // R5
   AST_LINK_UP_READY: assert property (@(posedge clk) disable iff (rst)
      link_up == (state_code == ST_READY)); // R6
   AST_DEADLINE_BOUND: assert property (@(posedge clk) disable iff (rst)
      in_window |-> dcnt < DEADLINE_CYCLES); // R7
   AST_LOSS_TO_GRACE: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_READY && !both_lock) |=> state_code == ST_GRACE); // R8
   AST_GRACE_RECOVER: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_GRACE && both_lock) |=> state_code == ST_READY); // R9
   AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (rst)
      (state_code == ST_GRACE) |-> gcnt < GRACE_CYCLES); // R9
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      state_code <= ST_GRACE); // R10
endmodule

bind link_bringup_seq link_bringup_seq_chk #(
   .QUIET_CYCLES(QUIET_CYCLES),
   .DEADLINE_CYCLES(DEADLINE_CYCLES),
   .GRACE_CYCLES(GRACE_CYCLES)
) chk_i (
   .clk(clk), .rst(rst), .rcfg_done(rcfg_done), .an_done(an_done),
   .lt_done(lt_done), .rx_align_lock(rx_align_lock), .rx_cdr_lock(rx_cdr_lock),
   .state_code(state_code), .rcfg_req(rcfg_req), .rcfg_mode(rcfg_mode),
   .tx_disable(tx_disable), .base_page_start(base_page_start), .link_up(link_up)
);

// File: tb/link_bringup_seq_tb_top.sv
module link_bringup_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int QUIET      = 20;
   localparam int DEADLINE   = 60;
   localparam int GRACE      = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst, an_lt_en, rcfg_done, an_done, lt_done, al_lock, cdr_lock;
   logic [3:0] state_code;
   logic [1:0] rcfg_mode;
   logic rcfg_req, tx_disable, base_page_start, link_up;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_bringup_seq #(
      .QUIET_CYCLES(QUIET), .DEADLINE_CYCLES(DEADLINE), .GRACE_CYCLES(GRACE)
   ) dut_i (
      .clk(clk), .rst(rst), .an_lt_en(an_lt_en), .rcfg_done(rcfg_done),
      .an_done(an_done), .lt_done(lt_done), .rx_align_lock(al_lock),
      .rx_cdr_lock(cdr_lock), .state_code(state_code), .rcfg_req(rcfg_req),
      .rcfg_mode(rcfg_mode), .tx_disable(tx_disable),
      .base_page_start(base_page_start), .link_up(link_up)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      chk(act == exp, req, what, act, exp);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_cfg();
      rcfg_done = 1'b1; tick(); rcfg_done = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1; an_lt_en = 1'b0; rcfg_done = 1'b0; an_done = 1'b0;
      lt_done = 1'b0; al_lock = 1'b0; cdr_lock = 1'b0;
      tick(); tick();
      rst = 1'b0;
   endtask

   // Wait out the quiet state; returns its length and the cycle of the base-page pulse
   task automatic ride_quiet(output int len, output int bp_at, output int bp_n);
      len = 0; bp_at = -1; bp_n = 0;
      while (state_code == 4'd2 && len < 10 * QUIET) begin
         len++;
         if (base_page_start) begin bp_at = len; bp_n++; end
         tick();
      end
   endtask

   // From enable (an_lt_en set) to lock check; uses 3 bounded-window cycles
   task automatic to_acquire();
      int len, bp_at, bp_n;
      an_lt_en = 1'b1; tick();
      pulse_cfg();
      ride_quiet(len, bp_at, bp_n);
      an_done = 1'b1; tick(); an_done = 1'b0;
      pulse_cfg();
      lt_done = 1'b1; tick(); lt_done = 1'b0;
      pulse_cfg();
   endtask

   task automatic t_reset_state();
      do_reset();
      tick();
      chk_eq("R1 R10", "state after reset", state_code, 0);
      chk_eq("R1", "rcfg_req after reset", rcfg_req, 0);
      chk_eq("R1", "tx_disable after reset", tx_disable, 0);
      chk_eq("R1", "base_page_start after reset", base_page_start, 0);
      chk_eq("R1", "link_up after reset", link_up, 0);
   endtask

   task automatic t_enable_gate();
      bit held = 1'b1;
      do_reset();
      rcfg_done = 1'b1; an_done = 1'b1; lt_done = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tick();
         if (state_code != 4'd0 || rcfg_req) held = 1'b0;
      end
      chk_eq("R1", "enable held while an_lt_en low", held, 1);
      rcfg_done = 1'b0; an_done = 1'b0; lt_done = 1'b0;
      an_lt_en = 1'b1; tick();
      chk_eq("R1 R10", "leave enable to AN reconfig", state_code, 1);
   endtask

   task automatic t_full_bringup();
      int len, bp_at, bp_n;
      bit held;
      do_reset();
      an_lt_en = 1'b1; tick();
      chk_eq("R2 R10", "AN reconfig state", state_code, 1);
      chk_eq("R2", "AN reconfig req", rcfg_req, 1);
      chk_eq("R2", "AN reconfig mode", rcfg_mode, 1);
      tick(); tick(); tick();
      chk_eq("R2", "AN reconfig holds without done", state_code, 1);
      pulse_cfg();
      chk_eq("R3 R10", "enter quiet", state_code, 2);
      chk_eq("R3", "tx_disable in quiet", tx_disable, 1);
      chk_eq("R2", "no req in quiet", rcfg_req, 0);
      rcfg_done = 1'b1; lt_done = 1'b1;
      ride_quiet(len, bp_at, bp_n);
      rcfg_done = 1'b0; lt_done = 1'b0;
      chk_eq("R3", "quiet length in cycles", len, QUIET);
      chk_eq("R4", "base page pulse cycle", bp_at, QUIET);
      chk_eq("R4", "base page pulse count", bp_n, 1);
      chk_eq("R4 R10", "negotiate state after quiet", state_code, 3);
      chk_eq("R3", "tx_disable released", tx_disable, 0);
      held = 1'b1;
      for (int i = 0; i < 4; i++) begin tick(); if (state_code != 4'd3) held = 1'b0; end
      chk_eq("R4", "negotiate holds without an_done", held, 1);
      an_done = 1'b1; tick(); an_done = 1'b0;
      chk_eq("R4 R10", "training reconfig after an_done", state_code, 4);
      chk_eq("R2", "training reconfig mode", rcfg_mode, 2);
      pulse_cfg();
      chk_eq("R5 R10", "training check state", state_code, 5);
      tick(); tick();
      chk_eq("R5", "training holds without lt_done", state_code, 5);
      lt_done = 1'b1; tick(); lt_done = 1'b0;
      chk_eq("R5 R10", "data reconfig after lt_done", state_code, 6);
      chk_eq("R2", "data reconfig mode", rcfg_mode, 3);
      chk_eq("R2", "data reconfig req", rcfg_req, 1);
      pulse_cfg();
      chk_eq("R6 R10", "lock check state", state_code, 7);
      chk_eq("R2", "mode idle outside reconfig", rcfg_mode, 0);
      tick();
      chk_eq("R6", "no lock stays in lock check", state_code, 7);
      al_lock = 1'b1; tick();
      chk_eq("R6", "alignment lock alone not enough", state_code, 7);
      chk_eq("R6", "link_up low before ready", link_up, 0);
      cdr_lock = 1'b1; tick();
      chk_eq("R6 R10", "ready with both locks", state_code, 8);
      chk_eq("R6", "link_up in ready", link_up, 1);
   endtask

   task automatic t_deadline_acquire();
      int n = 0;
      do_reset();
      to_acquire();
      chk_eq("R7", "reached lock check", state_code, 7);
      while (state_code == 4'd7 && n < 4 * DEADLINE) begin n++; tick(); end
      chk_eq("R7", "lock-check cycles before restart", n, DEADLINE - 3);
      chk_eq("R7", "restart to enable on deadline", state_code, 0);
      tick();
      chk_eq("R7", "sequence repeats after restart", state_code, 1);
   endtask

   task automatic t_deadline_training();
      int len, bp_at, bp_n;
      int n = 0;
      do_reset();
      an_lt_en = 1'b1; tick();
      pulse_cfg();
      ride_quiet(len, bp_at, bp_n);
      an_done = 1'b1; tick(); an_done = 1'b0;
      pulse_cfg();
      chk_eq("R7", "stalled in training", state_code, 5);
      while (state_code == 4'd5 && n < 4 * DEADLINE) begin n++; tick(); end
      chk_eq("R7", "training cycles before restart", n, DEADLINE - 1);
      chk_eq("R7", "deadline during training restarts", state_code, 0);
   endtask

   task automatic t_loss_recover();
      do_reset();
      to_acquire();
      al_lock = 1'b1; cdr_lock = 1'b1; tick();
      chk_eq("R6", "ready before loss", state_code, 8);
      cdr_lock = 1'b0; tick();
      chk_eq("R8 R10", "CDR loss enters wait", state_code, 9);
      chk_eq("R8", "link_up drops in wait", link_up, 0);
      tick(); tick();
      chk_eq("R9", "still waiting inside window", state_code, 9);
      cdr_lock = 1'b1; tick();
      chk_eq("R9", "lock return resumes ready", state_code, 8);
      al_lock = 1'b0; tick();
      chk_eq("R8", "alignment loss enters wait", state_code, 9);
      al_lock = 1'b1; tick();
      chk_eq("R9", "ready again after alignment returns", state_code, 8);
   endtask

   task automatic t_loss_timeout();
      int n = 0;
      do_reset();
      to_acquire();
      al_lock = 1'b1; cdr_lock = 1'b1; tick();
      al_lock = 1'b0; tick();
      while (state_code == 4'd9 && n < 4 * GRACE) begin n++; tick(); end
      chk_eq("R9", "grace window length", n, GRACE);
      chk_eq("R9", "grace expiry goes to enable", state_code, 0);
   endtask

   task automatic t_reset_midlink();
      do_reset();
      to_acquire();
      al_lock = 1'b1; cdr_lock = 1'b1; tick();
      rst = 1'b1; tick(); rst = 1'b0;
      chk_eq("R1", "reset from ready to enable", state_code, 0);
      chk_eq("R1", "link_up cleared by reset", link_up, 0);
   endtask

   initial begin
      rst = 1'b1; an_lt_en = 1'b0; rcfg_done = 1'b0; an_done = 1'b0;
      lt_done = 1'b0; al_lock = 1'b0; cdr_lock = 1'b0;
      t_reset_state();
      t_enable_gate();
      t_full_bringup();
      t_deadline_acquire();
      t_deadline_training();
      t_loss_recover();
      t_loss_timeout();
      t_reset_midlink();
      summary();
      $finish;
   end
endmodule